// File: doc/BRIEF.md
# HDLC Receive Status Tracker

This block sits between an HDLC receive deframer and a host register interface. The deframer reports one event per cycle: a flag, one idle character time, a frame start, a data byte, a frame end or an abort. Data bytes go into a small receive FIFO. Each entry carries an end-of-frame tag and an abort tag. The host drains the FIFO through a valid/ready port. The abort and end-of-frame status bits, and the frame-complete event, are driven by the tags of the byte the host most recently popped, not by the arrival of bytes.

A one-entry staging register holds the newest byte. It is written into the FIFO when the next byte arrives, or when the frame ends or aborts. That way the last byte of a frame enters the FIFO with its tags already set. When the host pops the last byte of a frame, the block loads an information buffer with that frame's byte count and its abort flag. The block also records when a frame was lost to an overrun, and when unread frame information was overwritten. Sticky status bits are cleared by a write-one-to-clear strobe.

The input port cannot stall the deframer. `in_ready` is low while the FIFO is full, and a byte pushed in that state is lost and counts as an overrun. `out_data` is valid while `out_valid` is high. A pop happens on a cycle where both `out_valid` and `out_ready` are high. `out_data` holds steady until it is popped.

Top module: `hdlc_rx_status`

## Requirements
- R1: status[0] (in frame) becomes 1 the cycle after a frame start. It returns to 0 the cycle after a frame end or an abort. Flags and idle times do not set it.
- R2: status[2] (timeout) sets after four back-to-back flag events, or after four back-to-back idle events. Any other event between them restarts the count. The bit is sticky until cleared.
- R3: After each pop, status[3] (end of frame) equals 1 exactly when the popped byte was the last byte of its frame.
- R4: After each pop, status[1] (abort) equals 1 exactly when the popped byte was the last byte kept before an abort. Whenever status[1] is 1, status[3] is also 1.
- R5: status[4] (frame lost) sets when the first byte of a new frame is pushed while the FIFO is full.
- R6: Popping the last byte of a frame sets status[6] (frame complete). The same pop loads `info_count` with the frame's byte count and `info_abort` with its abort tag, and sets `info_unread`. A pulse on `info_rd` clears `info_unread`.
- R7: status[5] (info lost) sets when the last byte of a frame is popped while `info_unread` is still 1.
- R8: A `clr_wr` pulse clears each of status bits 2, 4, 5, 6 and 7 whose `clr_data` bit is 1. `clr_data` bits 0, 1 and 3 have no effect, and a 0 bit leaves its status bit unchanged. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: The FIFO holds 16 entries and returns bytes in arrival order. A byte pushed while the FIFO is full is dropped and sets status[7] (overrun), which is sticky. `in_ready` is low exactly while the FIFO is full.
- R10: Reset clears every status bit, empties the FIFO, and clears `info_unread`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_flag | input | 1 | Flag seen |
| evt_idle | input | 1 | One character time of idle or space |
| evt_start | input | 1 | Frame start |
| evt_end | input | 1 | Frame end, after the last byte |
| evt_abort | input | 1 | Abort detected |
| in_valid | input | 1 | Data byte present |
| in_data | input | 8 | Received data byte |
| in_ready | output | 1 | FIFO not full (advisory, no stall) |
| out_valid | output | 1 | FIFO holds a byte |
| out_ready | input | 1 | Host pops the head byte |
| out_data | output | 8 | Head byte of the FIFO |
| info_rd | input | 1 | Host read of the information buffer |
| info_count | output | 12 | Byte count of the last completed frame |
| info_abort | output | 1 | Abort tag of the last completed frame |
| info_unread | output | 1 | Information buffer not yet read |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 8 | Write-one-to-clear mask, aligned to `status` |
| status | output | 8 | {overrun, complete, info lost, frame lost, eof, timeout, abort, in frame} |

## Verification
Two things can fall in the same cycle: the pop of a frame's last byte, which sets frame complete, and a host write of 1 that clears that same bit. The bench pops an end-tagged byte while `clr_wr` carries the complete bit, then checks that the bit reads 1 on the following cycle. A frame-length sweep with both endings, together with the timeout, info-loss and overrun sequences, computes every expected tag, count and flag from the frame layout the bench itself generated.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              abort;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  localparam int ST_INFRAME = 0;
  localparam int ST_ABORT   = 1;
  localparam int ST_TMO     = 2;
  localparam int ST_EOF     = 3;
  localparam int ST_FLOST   = 4;
  localparam int ST_ILOST   = 5;
  localparam int ST_CMPL    = 6;
  localparam int ST_OVR     = 7;
  localparam int ST_W       = 8;
endpackage

// File: rtl/hdlc_rx_stage.sv
module hdlc_rx_stage
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_end,
  input  logic              frame_abort,
  output logic              push,
  output rx_entry_t         push_entry
);
  logic              held_q;
  logic [BYTE_W-1:0] held_data_q;

  // The held byte leaves when it is known whether it closes its frame.
  always_comb begin
    push       = 1'b0;
    push_entry = '{abort: 1'b0, eof: 1'b0, data: held_data_q};
    if (held_q) begin
      if (byte_valid) begin
        push = 1'b1;
      end else if (frame_end) begin
        push           = 1'b1;
        push_entry.eof = 1'b1;
      end else if (frame_abort) begin
        push             = 1'b1;
        push_entry.eof   = 1'b1;
        push_entry.abort = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= 1'b0;
      held_data_q <= '0;
    end else if (byte_valid) begin
      held_q      <= 1'b1;
      held_data_q <= byte_data;
    end else if (frame_end || frame_abort) begin
      held_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_rx_tagfifo.sv
module hdlc_rx_tagfifo
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  rx_entry_t push_entry,
  output logic      full,
  output logic      overflow,
  output logic      head_valid,
  input  logic      head_take,
  output rx_entry_t head_entry
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wptr_q, rptr_q;
  logic [CW-1:0]   cnt_q;
  logic            do_wr, do_rd;

  assign full       = (cnt_q == FULL_CNT);
  assign head_valid = (cnt_q != '0);
  assign head_entry = mem[rptr_q];
  assign do_wr      = push && !full;
  assign do_rd      = head_take && head_valid;
  assign overflow   = push && full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_rd) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_rx_timeout.sv
module hdlc_rx_timeout #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_flag,
  input  logic ev_idle,
  input  logic ev_other,
  output logic hit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q [2];
  logic [1:0]    ev, hit_v;

  assign ev  = {ev_idle, ev_flag};
  assign hit = |hit_v;

  for (genvar g = 0; g < 2; g++) begin : g_run
    logic breaker;
    assign breaker  = ev_other || ev[1-g];
    assign hit_v[g] = ev[g] && (run_q[g] == LAST);
    always_ff @(posedge clk) begin
      if (rst || breaker || hit_v[g]) run_q[g] <= '0;
      else if (ev[g])                 run_q[g] <= run_q[g] + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CNT_W      = 12,
  parameter int TMO_EVENTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_flag,
  input  logic              evt_idle,
  input  logic              evt_start,
  input  logic              evt_end,
  input  logic              evt_abort,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  input  logic              info_rd,
  output logic [CNT_W-1:0]  info_count,
  output logic              info_abort,
  output logic              info_unread,
  input  logic              clr_wr,
  input  logic [ST_W-1:0]   clr_data,
  output logic [ST_W-1:0]   status
);
  logic      push, full, ovf, tmo_hit;
  rx_entry_t push_entry, head;
  logic      pop, pop_last;
  logic [ST_W-1:0] w1c;

  logic             in_frame_q, abort_q, tmo_q, eof_q;
  logic             flost_q, ilost_q, cmpl_q, ovr_q;
  logic             first_pend_q, unread_q;
  logic [CNT_W-1:0] rd_cnt_q, info_cnt_q;
  logic             info_ab_q;

  hdlc_rx_stage u_stage (
    .clk, .rst,
    .byte_valid (in_valid),
    .byte_data  (in_data),
    .frame_end  (evt_end),
    .frame_abort(evt_abort),
    .push,
    .push_entry
  );

  hdlc_rx_tagfifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst,
    .push,
    .push_entry,
    .full,
    .overflow  (ovf),
    .head_valid(out_valid),
    .head_take (out_ready),
    .head_entry(head)
  );

  hdlc_rx_timeout #(.RUN_LEN(TMO_EVENTS)) u_tmo (
    .clk, .rst,
    .ev_flag (evt_flag),
    .ev_idle (evt_idle),
    .ev_other(evt_start || evt_end || evt_abort || in_valid),
    .hit     (tmo_hit)
  );

  assign in_ready = !full;
  assign out_data = head.data;
  assign pop      = out_valid && out_ready;
  assign pop_last = pop && head.eof;
  assign w1c      = clr_wr ? clr_data : '0;

  // Receive-side state: frame tracking and sticky loss flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q   <= 1'b0;
      first_pend_q <= 1'b0;
      tmo_q        <= 1'b0;
      flost_q      <= 1'b0;
      ovr_q        <= 1'b0;
    end else begin
      if (evt_start)                 in_frame_q <= 1'b1;
      else if (evt_end || evt_abort) in_frame_q <= 1'b0;
      if (evt_start)  first_pend_q <= 1'b1;
      else if (push)  first_pend_q <= 1'b0;
      tmo_q   <= tmo_hit | (tmo_q & ~w1c[ST_TMO]);
      flost_q <= (ovf & first_pend_q) | (flost_q & ~w1c[ST_FLOST]);
      ovr_q   <= ovf | (ovr_q & ~w1c[ST_OVR]);
    end
  end

  // Host-side state: follows the most recently popped entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      eof_q      <= 1'b0;
      abort_q    <= 1'b0;
      cmpl_q     <= 1'b0;
      ilost_q    <= 1'b0;
      unread_q   <= 1'b0;
      rd_cnt_q   <= '0;
      info_cnt_q <= '0;
      info_ab_q  <= 1'b0;
    end else begin
      if (pop) begin
        eof_q   <= head.eof;
        abort_q <= head.abort;
      end
      cmpl_q  <= pop_last | (cmpl_q & ~w1c[ST_CMPL]);
      ilost_q <= (pop_last & unread_q) | (ilost_q & ~w1c[ST_ILOST]);
      if (pop_last)     unread_q <= 1'b1;
      else if (info_rd) unread_q <= 1'b0;
      if (pop_last) begin
        rd_cnt_q   <= '0;
        info_cnt_q <= rd_cnt_q + 1'b1;
        info_ab_q  <= head.abort;
      end else if (pop) begin
        rd_cnt_q <= rd_cnt_q + 1'b1;
      end
    end
  end

  assign info_count  = info_cnt_q;
  assign info_abort  = info_ab_q;
  assign info_unread = unread_q;

  always_comb begin
    status             = '0;
    status[ST_INFRAME] = in_frame_q;
    status[ST_ABORT]   = abort_q;
    status[ST_TMO]     = tmo_q;
    status[ST_EOF]     = eof_q;
    status[ST_FLOST]   = flost_q;
    status[ST_ILOST]   = ilost_q;
    status[ST_CMPL]    = cmpl_q;
    status[ST_OVR]     = ovr_q;
  end
endmodule

// File: rtl/hdlc_rx_status_chk.sv
module hdlc_rx_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       evt_start,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       info_unread,
  input logic       clr_wr,
  input logic [7:0] clr_data,
  input logic [7:0] status
);
  p_inframe_r1: assert property (@(posedge clk) disable iff (rst)
    evt_start |=> status[0]);

  p_tmo_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (status[2] && !(clr_wr && clr_data[2])) |=> status[2]);

  p_abort_eof_r4: assert property (@(posedge clk) disable iff (rst)
    status[1] |-> status[3]);

  p_lost_full_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[4]) |-> $past(!in_ready));

  p_cmpl_pop_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status[6]) |-> $past(out_valid && out_ready));

  p_ilost_unread_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(status[5]) |-> $past(info_unread && out_valid && out_ready));

  p_ovr_full_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(status[7]) |-> $past(!in_ready));
endmodule

bind hdlc_rx_status hdlc_rx_status_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_start  (evt_start),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .info_unread(info_unread),
  .clr_wr     (clr_wr),
  .clr_data   (clr_data),
  .status     (status)
);

// File: tb/test_hdlc_rx_status.sv
module test_hdlc_rx_status;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_flag = 0, evt_idle = 0, evt_start = 0, evt_end = 0, evt_abort = 0;
  logic in_valid = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid;
  logic out_ready = 0;
  logic [7:0] out_data;
  logic info_rd = 0;
  logic [11:0] info_count;
  logic info_abort, info_unread;
  logic clr_wr = 0;
  logic [7:0] clr_data = '0;
  logic [7:0] status;

  int n_chk = 0, n_err = 0;

  always #(PERIOD/2) clk = ~clk;

  hdlc_rx_status i_hdlc_rx_status (
    .clk, .rst, .evt_flag, .evt_idle, .evt_start, .evt_end, .evt_abort,
    .in_valid, .in_data, .in_ready, .out_valid, .out_ready, .out_data,
    .info_rd, .info_count, .info_abort, .info_unread,
    .clr_wr, .clr_data, .status
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 flag, 1 idle, 2 start, 3 byte, 4 end, 5 abort
  task automatic ev(input int kind, input logic [7:0] d = 8'h00);
    evt_flag  = (kind == 0);
    evt_idle  = (kind == 1);
    evt_start = (kind == 2);
    in_valid  = (kind == 3);
    in_data   = d;
    evt_end   = (kind == 4);
    evt_abort = (kind == 5);
    @(negedge clk);
    {evt_flag, evt_idle, evt_start, in_valid, evt_end, evt_abort} = '0;
  endtask

  task automatic pop(output logic [7:0] d, input logic cw = 1'b0, input logic [7:0] cd = 8'h00);
    d = out_data;
    out_ready = 1'b1;
    clr_wr = cw;
    clr_data = cd;
    @(negedge clk);
    out_ready = 1'b0;
    clr_wr = 1'b0;
  endtask

  task automatic clear(input logic [7:0] cd);
    clr_wr = 1'b1;
    clr_data = cd;
    @(negedge clk);
    clr_wr = 1'b0;
  endtask

  task automatic rd_info();
    info_rd = 1'b1;
    @(negedge clk);
    info_rd = 1'b0;
  endtask

  task automatic frame(input int len, input logic ab, input logic [7:0] base);
    ev(2);
    for (int i = 0; i < len; i++) ev(3, base + 8'(i));
    ev(ab ? 5 : 4);
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 status", status, 8'h00);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 info_unread", info_unread, 0);

    // R1: in-frame tracking
    ev(0);
    chk("R1 flag leaves idle", status[0], 0);
    ev(2);
    chk("R1 start sets", status[0], 1);
    ev(4);
    chk("R1 end clears", status[0], 0);

    // R3 R4 R6 R9: sweep frame length and ending
    for (int len = 1; len <= 6; len++) begin
      for (int ab = 0; ab < 2; ab++) begin
        logic [7:0] base;
        base = 8'(len * 16 + ab * 8);
        frame(len, ab[0], base);
        if (ab == 1) chk("R1 abort clears", status[0], 0);
        for (int i = 0; i < len; i++) begin
          chk("R9 valid", out_valid, 1);
          pop(d);
          chk("R9 order", d, base + 8'(i));
          chk("R3 eof tag", status[3], (i == len - 1) ? 1 : 0);
          chk("R4 abort tag", status[1], (ab == 1 && i == len - 1) ? 1 : 0);
          chk("R6 complete", status[6], (i == len - 1) ? 1 : 0);
        end
        chk("R9 drained", out_valid, 0);
        chk("R6 info count", info_count, len);
        chk("R6 info abort", info_abort, ab);
        chk("R6 unread set", info_unread, 1);
        rd_info();
        chk("R6 unread cleared", info_unread, 0);
        clear(8'h40);
        chk("R8 complete cleared", status[6], 0);
      end
    end

    // R7: two frames, info never read
    frame(2, 1'b0, 8'hA0);
    frame(3, 1'b0, 8'hB0);
    for (int i = 0; i < 2; i++) pop(d);
    chk("R7 first frame no loss", status[5], 0);
    for (int i = 0; i < 3; i++) pop(d);
    chk("R7 info lost", status[5], 1);
    chk("R7 newest count", info_count, 3);

    // R8: zero write and read-only bits
    clear(8'h00);
    chk("R8 zero write keeps", status & 8'h68, 8'h68);
    clear(8'hFF);
    chk("R8 ro eof kept, sticky cleared", status, 8'h08);

    // R8: set and clear of complete in the same cycle
    rd_info();
    frame(1, 1'b0, 8'h55);
    pop(d, 1'b1, 8'h40);
    chk("R8 set beats clear", status[6], 1);
    clear(8'h40);

    // R2: timeout from flags and idle
    for (int k = 0; k < 3; k++) ev(0);
    chk("R2 three flags", status[2], 0);
    ev(0);
    chk("R2 four flags", status[2], 1);
    clear(8'h04);
    chk("R2 cleared", status[2], 0);
    for (int k = 0; k < 3; k++) ev(1);
    ev(0);
    for (int k = 0; k < 3; k++) ev(1);
    chk("R2 broken idle run", status[2], 0);
    ev(1);
    chk("R2 four idles", status[2], 1);
    clear(8'h04);

    // R9 R5: overrun inside a frame, then lost frame
    frame(17, 1'b0, 8'h00);
    chk("R9 full", in_ready, 0);
    chk("R9 overrun", status[7], 1);
    chk("R5 no loss mid frame", status[4], 0);
    frame(1, 1'b0, 8'hEE);
    chk("R5 frame lost", status[4], 1);
    clear(8'h90);
    chk("R8 clear loss bits", status[7:4] & 4'b1001, 4'b0000);
    pop(d);
    chk("R9 first kept byte", d, 8'h00);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule